// File: doc/BRIEF.md
# Programmable Passive LCD Timing Generator

This block produces the horizontal and vertical scan timing for an LCD panel. A small bank of byte-wide registers sets the timing. The registers are written through a simple port with an address, a data byte and a write strobe. The horizontal pixel counter advances on each cycle where the pixel-clock enable is high. When a line is complete, the line counter advances. From the two counters the block derives four outputs: a line pulse, a frame pulse, a display-active flag, and the counter values themselves.

The visible width, visible height and the two blanking lengths come from register values through fixed offset and scale rules. Horizontal lengths are counted in groups of eight pixels. Writes go to a staging copy. The staging copy moves into the working copy only when the frame wraps, so a single frame never mixes old and new settings. By default the panel is passive. In passive mode the two pulse-position registers are ignored and both pulses sit at the start of their blanking periods.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register is zero, so a frame is 8 visible pixels plus 32 blanking pixels per line, with 1 visible line and no blanking lines. Both counters start at 0.
- R2: Visible pixels per line equal (byte at address 1 + 1) × 8.
- R3: Blanking pixels per line equal (byte at address 4 + 4) × 8. The column counter runs from 0 to visible + blanking − 1, then returns to 0, and at that point the row counter advances by one.
- R4: Visible lines equal a 10-bit value + 1. Bits 7:0 of the value come from address 2, and bits 9:8 come from bits 1:0 of address 3.
- R5: Blanking lines equal the byte at address 5, used directly. The row counter returns to 0 after visible + blanking lines.
- R6: The line pulse is high for exactly 8 columns. In passive mode those are columns V through V+7, where V is the visible width.
- R7: The frame pulse is high for the whole row whose index equals the visible height, in passive mode. It never rises when the blanking-line count is 0.
- R8: The display-active flag is high only when the column is below the visible width and the row is below the visible height.
- R9: Bit 0 of address 0 selects active mode when set and passive mode when clear. In active mode the line pulse starts at V + 8 × (byte at address 6), and the frame pulse sits on row H + (byte at address 7), where H is the visible height. In passive mode addresses 6 and 7 have no effect.
- R10: Written values take effect only on the clock edge at which the frame wraps from the last column of the last row. A write in that same cycle lands one frame later.
- R11: While the pixel enable is low, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | Pixel-clock enable; the counters advance when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| line_pulse | output | 1 | Line pulse, 8 pixels wide |
| frame_pulse | output | 1 | Frame pulse, one line long |
| disp_active | output | 1 | High inside the visible window |
| col_cnt | output | COL_W | Current pixel column |
| row_cnt | output | ROW_W | Current line |

## Verification
A register write and a frame wrap can fall in the same clock cycle. The wrap then loads the staging copy as it stood before that write. The bench provokes this by steering its own model to the last pixel of the last row and issuing a blanking-line write in exactly that cycle. It then judges the result by comparing every output on every following pixel against arithmetic expectations. Those expectations keep the old value for one more frame and the new value after the next wrap. The exchange of the whole 10-bit height at a wrap is also swept through a 257-line frame.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int REG_W      = 8;
  localparam int REG_ADDR_W = 3;
  localparam int GRP_SHIFT  = 3;   // 8-pixel groups
  localparam int CALC_W     = 16;

  typedef struct packed {
    logic             tft_mode;
    logic [REG_W-1:0] h_vis;
    logic [9:0]       v_vis;
    logic [REG_W-1:0] h_blk;
    logic [REG_W-1:0] v_blk;
    logic [REG_W-1:0] lp_pos;
    logic [REG_W-1:0] fp_pos;
  } tg_cfg_t;

  function automatic logic [CALC_W-1:0] vis_px(input logic [REG_W-1:0] r);
    return (CALC_W'(r) + CALC_W'(1)) << GRP_SHIFT;
  endfunction

  function automatic logic [CALC_W-1:0] blk_px(input logic [REG_W-1:0] r);
    return (CALC_W'(r) + CALC_W'(4)) << GRP_SHIFT;
  endfunction

  function automatic logic [CALC_W-1:0] vis_ln(input logic [9:0] r);
    return CALC_W'(r) + CALC_W'(1);
  endfunction

  function automatic logic [CALC_W-1:0] grp_px(input logic [REG_W-1:0] r);
    return CALC_W'(r) << GRP_SHIFT;
  endfunction
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  apply,
  output tg_cfg_t               work
);
  tg_cfg_t stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: stage.tft_mode    <= wr_data[0];
        3'd1: stage.h_vis       <= wr_data;
        3'd2: stage.v_vis[7:0]  <= wr_data;
        3'd3: stage.v_vis[9:8]  <= wr_data[1:0];
        3'd4: stage.h_blk       <= wr_data;
        3'd5: stage.v_blk       <= wr_data;
        3'd6: stage.lp_pos      <= wr_data;
        default: stage.fp_pos   <= wr_data;
      endcase
    end
  end

  // working copy changes only at the frame wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     work <= '0;
    else if (apply) work <= stage;
  end
endmodule

// File: rtl/lcd_tg_wrapcnt.sv
module lcd_tg_wrapcnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (step)   cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int COL_W = 13,
  parameter int ROW_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_en,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  output logic                  line_pulse,
  output logic                  frame_pulse,
  output logic                  disp_active,
  output logic [COL_W-1:0]      col_cnt,
  output logic [ROW_W-1:0]      row_cnt
);
  localparam int CW = COL_W + 1;
  localparam int RW = ROW_W + 1;

  tg_cfg_t          cfg;
  logic [COL_W-1:0] h_act, h_tot;
  logic [ROW_W-1:0] v_act, v_tot;
  logic             h_last, v_last;
  logic             line_wrap, frame_wrap;
  logic [CW-1:0]    lp_start;
  logic [RW-1:0]    fp_line;

  assign h_act = COL_W'(vis_px(cfg.h_vis));
  assign h_tot = h_act + COL_W'(blk_px(cfg.h_blk));
  assign v_act = ROW_W'(vis_ln(cfg.v_vis));
  assign v_tot = v_act + ROW_W'(cfg.v_blk);

  assign line_wrap  = pix_en & h_last;
  assign frame_wrap = line_wrap & v_last;

  lcd_tg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .apply(frame_wrap), .work(cfg)
  );

  lcd_tg_wrapcnt #(.W(COL_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step(pix_en), .last(h_tot - COL_W'(1)),
    .cnt(col_cnt), .at_last(h_last)
  );

  lcd_tg_wrapcnt #(.W(ROW_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(line_wrap), .last(v_tot - ROW_W'(1)),
    .cnt(row_cnt), .at_last(v_last)
  );

  // pulse positions: passive mode pins them to the blanking start
  assign lp_start = {1'b0, h_act} + (cfg.tft_mode ? CW'(grp_px(cfg.lp_pos)) : CW'(0));
  assign fp_line  = {1'b0, v_act} + (cfg.tft_mode ? RW'(cfg.fp_pos) : RW'(0));

  assign line_pulse  = ({1'b0, col_cnt} >= lp_start) && ({1'b0, col_cnt} < lp_start + CW'(8));
  assign frame_pulse = ({1'b0, row_cnt} == fp_line);
  assign disp_active = (col_cnt < h_act) && (row_cnt < v_act);
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int COL_W = 13,
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [COL_W-1:0] col_cnt,
  input logic [ROW_W-1:0] row_cnt,
  input logic [COL_W-1:0] h_tot,
  input logic [COL_W-1:0] h_act,
  input logic [ROW_W-1:0] v_tot,
  input logic [ROW_W-1:0] v_act,
  input logic             line_wrap,
  input logic             frame_wrap,
  input logic             line_pulse,
  input logic             frame_pulse,
  input logic             disp_active
);
  assert_col_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_cnt < h_tot);
  assert_row_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_cnt < v_tot);
  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && !frame_wrap) |=> row_cnt == ROW_W'($past(row_cnt) + ROW_W'(1)));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(col_cnt) && $stable(row_cnt)));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (col_cnt == '0 && row_cnt == '0));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> ($stable(h_tot) && $stable(v_tot) && $stable(h_act) && $stable(v_act)));
  assert_no_pulse_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> (!line_pulse && !frame_pulse));
  assert_lp_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> col_cnt >= h_act);
endmodule

bind lcd_timing_gen lcd_tg_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .col_cnt(col_cnt), .row_cnt(row_cnt),
  .h_tot(h_tot), .h_act(h_act), .v_tot(v_tot), .v_act(v_act),
  .line_wrap(line_wrap), .frame_wrap(frame_wrap), .line_pulse(line_pulse),
  .frame_pulse(frame_pulse), .disp_active(disp_active)
);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic        clk = 0, rst_n = 0, pix_en = 0, wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_pulse, frame_pulse, disp_active;
  logic [12:0] col_cnt;
  logic [10:0] row_cnt;

  int n_chk = 0, n_bad = 0;
  int m_col = 0, m_row = 0;
  int stg[8];
  int wrk[8];

  always #4 clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
    .disp_active(disp_active), .col_cnt(col_cnt), .row_cnt(row_cnt)
  );

  function automatic int e_hact();  return (wrk[1] + 1) * 8; endfunction           // R2
  function automatic int e_htot();  return e_hact() + (wrk[4] + 4) * 8; endfunction // R3
  function automatic int e_vact();  return wrk[2] + 256 * (wrk[3] % 4) + 1; endfunction // R4
  function automatic int e_vtot();  return e_vact() + wrk[5]; endfunction           // R5
  function automatic bit e_tft();   return wrk[0] % 2 == 1; endfunction             // R9

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int lps, fpl;
    bit lp, fp, da;
    lps = e_hact() + (e_tft() ? wrk[6] * 8 : 0);
    fpl = e_vact() + (e_tft() ? wrk[7] : 0);
    lp  = (m_col >= lps) && (m_col < lps + 8);
    fp  = (m_row == fpl);
    da  = (m_col < e_hact()) && (m_row < e_vact());
    chk(int'(col_cnt) == m_col, "R3 col", int'(col_cnt), m_col);
    chk(int'(row_cnt) == m_row, "R3 row", int'(row_cnt), m_row);
    chk(line_pulse == lp, "R6 line_pulse", int'(line_pulse), int'(lp));
    chk(frame_pulse == fp, "R7 frame_pulse", int'(frame_pulse), int'(fp));
    chk(disp_active == da, "R8 disp_active", int'(disp_active), int'(da));
  endtask

  function automatic bit at_wrap();
    return (m_col == e_htot() - 1) && (m_row == e_vtot() - 1);
  endfunction

  task automatic tick(input bit en, input bit we, input int a, input int d);
    @(negedge clk);
    pix_en = en; wr_en = we; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk);
    #1;
    if (en) begin
      if (m_col == e_htot() - 1) begin
        m_col = 0;
        if (m_row == e_vtot() - 1) begin
          m_row = 0;
          foreach (wrk[i]) wrk[i] = stg[i];   // R10: old staging applies
        end else m_row++;
      end else m_col++;
    end
    if (we) stg[a] = d;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    tick(0, 1, a, d);   // R11: counters hold during the write
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    foreach (stg[i]) begin stg[i] = 0; wrk[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1; compare();                        // R1 reset state
    run(90);                              // R1: 40-pixel single-line frame, no frame pulse

    // passive, 16+32 px, 4+2 lines; pulse position registers set but ignored (R9)
    wr(1, 1); wr(2, 3); wr(3, 0); wr(4, 0); wr(5, 2); wr(6, 2); wr(7, 1);
    run(40 + 288 * 2);                    // R2 R3 R4 R5 R6 R7
    wr(4, 1);                             // R10: written mid-frame, waits for wrap
    run(100);
    tick(1, 1, 1, 2);                     // R10: write while counting
    run(300 * 3);

    wr(0, 1);                             // R9: active mode moves both pulses
    run(320 * 3 + 400);
    wr(6, 40);                            // R9: pulse start past line end
    run(320 * 2 + 400);

    // R4: 10-bit height, 257 lines
    wr(0, 0); wr(1, 0); wr(4, 0); wr(2, 0); wr(3, 1); wr(5, 3);
    while (!(e_vact() == 257 && m_row == 5)) tick(1, 0, 0, 0);
    while (!at_wrap()) tick(1, 0, 0, 0);
    tick(1, 1, 5, 0);                     // R10: write in the wrap cycle lands one frame later
    run(40 * 260 + 40);                   // frame still has 3 blank lines
    run(40 * 258 + 80);                   // R7: no frame pulse with zero blank lines

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule